// File: doc/BRIEF.md
# Single-Wire Serial Identity Responder

This block is a slave on a shared single-wire, open-drain bus. It gives a bus master a fixed 64-bit identity. The identity is built from a constant family byte (01h), a 48-bit serial number set by a parameter, and an 8-bit checksum. The block computes the checksum itself, when the design is elaborated. Every bit on the wire travels least significant bit first.

All timing is counted in ticks of an enable input. Each tick stands for about one microsecond. The master owns every slot and starts each one with a falling edge. The block watches the sampled line level and does the following:

- It answers a long low pulse with a presence pulse.
- It reads command bytes from the master's write slots.
- It drives read slots by pulling the line low for a 0 bit.
- It takes part in the address-selection commands that let several identical slaves share one wire.

The block never drives the line high. Its only output onto the bus is a pull-down request. A `selected` flag tells the rest of the chip that this device has been addressed on its own.

Top module: `onewire_id_responder`

## Requirements
- R1: The identity word has bits [7:0] = 01h, bits [55:8] = the 48-bit serial parameter and bits [63:56] = the checksum. Identity bit 0 is the first bit to go on the wire.
- R2: The checksum is the reflected CRC-8 with polynomial x^8+x^5+x^4+1 and a zero start value. It is computed over identity bits 0 to 55 in wire order. For each bit, the feedback is crc[0] XOR the data bit, the register shifts right, and it is XORed with 8Ch when the feedback is 1.
- R3: The block pulls the bus only in two cases: during the presence pulse, or in a read slot that the master has already opened with a falling edge. When it pulls in a read slot, it releases the line exactly T_SAMPLE ticks after it started. The bus_pull output is 0 while rst is held.
- R4: Once the line has been low for more than T_RST ticks without the block pulling it, the block leaves whatever phase it was in and clears `selected`. It does not pull the line again until the line is released.
- R5: After a reset low is released, the block waits T_PWAIT ticks, then pulls the line for exactly T_PLEN ticks.
- R6: In a write slot, the block samples the line T_SAMPLE ticks after the falling edge: high is 1 and low is 0. A command byte arrives least significant bit first, so the wire sequence of byte CCh is not taken as 33h.
- R7: Command 33h or 0Fh starts 64 read slots that carry identity bits 0 to 63 in order. A 0 bit is sent as a pull and a 1 bit as a release. `selected` rises after the last slot.
- R8: Command 55h takes 64 written bits and compares each with the matching identity bit. If all 64 match, `selected` rises. A single difference makes the block silent and unselected until the next reset.
- R9: Command F0h runs 64 rounds. Each round is a read slot carrying the identity bit, a read slot carrying its complement, and a write slot. If the written bit differs from the identity bit, the block goes silent. If all 64 rounds complete, `selected` rises.
- R10: Any command byte other than 33h, 0Fh, 55h or F0h leaves the block silent until the next reset: no pull in later read slots, and `selected` stays low.
- R11: Once a command has run to completion, later read slots see no pull from the block until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable, about once per microsecond; the timing base |
| bus_in | input | 1 | Sampled level of the shared line |
| bus_pull | output | 1 | 1 requests the open-drain pull-down of the line |
| selected | output | 1 | Device has been addressed alone by a completed command |

## Verification
Read ROM is run twice. The first time it is cut short by a reset after a few bits. The second time it runs to the end. This separates a correct reset override from a block that carries on where it stopped. A read slot that carries a 0 is sampled early and again late, which shows a bounded pull apart from a stuck one. Match ROM is tried with the true identity and with one bit flipped at a random position, to separate a real comparison from one that accepts anything. Search ROM is run to completion once and broken off at a random round once. The bit-reversed 33h byte and random unknown commands show that bit order matters and that unknown commands keep the block silent.

// File: rtl/onewire_id_pkg.sv
package onewire_id_pkg;

    localparam int          ID_BITS     = 64;
    localparam int          SER_BITS    = 48;
    localparam int          BODY_BITS   = ID_BITS - 8;
    localparam int          IDX_W       = $clog2(ID_BITS);
    localparam logic [7:0]  FAMILY_CODE = 8'h01;
    localparam logic [7:0]  CRC_REFL    = 8'h8C;

    localparam logic [7:0]  OP_READ_A   = 8'h33;
    localparam logic [7:0]  OP_READ_B   = 8'h0F;
    localparam logic [7:0]  OP_MATCH    = 8'h55;
    localparam logic [7:0]  OP_SEARCH   = 8'hF0;

    typedef enum logic [2:0] {
        PH_QUIET,
        PH_RST_LOW,
        PH_PRES_WAIT,
        PH_PRES_DRV,
        PH_CMD,
        PH_READ,
        PH_MATCH,
        PH_SEARCH
    } phase_e;

    typedef enum logic [1:0] {
        SR_TRUE,
        SR_CMPL,
        SR_DIR
    } search_e;

    typedef struct packed {
        phase_e             phase;
        search_e            sub;
        logic [IDX_W-1:0]   idx;
        logic [2:0]         bcnt;
        logic [7:0]         cmd;
        logic               in_slot;
        logic               pull;
        logic               sel;
    } eng_state_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic din);
        logic       fb;
        logic [7:0] nxt;
        fb  = crc[0] ^ din;
        nxt = crc >> 1;
        if (fb) nxt = nxt ^ CRC_REFL;
        return nxt;
    endfunction

    function automatic phase_e decode_cmd(input logic [7:0] op);
        phase_e ph;
        case (op)
            OP_READ_A, OP_READ_B: ph = PH_READ;
            OP_MATCH:             ph = PH_MATCH;
            OP_SEARCH:            ph = PH_SEARCH;
            default:              ph = PH_QUIET;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/ow_id_rom.sv
module ow_id_rom
    import onewire_id_pkg::*;
#(
    parameter logic [SER_BITS-1:0] SERIAL_NUM = '0
) (
    output logic [ID_BITS-1:0] id_word
);

    logic [BODY_BITS-1:0] body;
    logic [7:0]           chain [BODY_BITS+1];

    assign body     = {SERIAL_NUM, FAMILY_CODE};
    assign chain[0] = 8'h00;

    generate
        for (genvar i = 0; i < BODY_BITS; i++) begin : g_crc
            assign chain[i+1] = crc8_step(chain[i], body[i]);
        end
    endgenerate

    assign id_word = {chain[BODY_BITS], body};

endmodule

// File: rtl/ow_line_monitor.sv
module ow_line_monitor #(
    parameter int T_RST = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic bus_in,
    input  logic own_pull,
    output logic fell,
    output logic rst_req
);

    localparam int CW = $clog2(T_RST + 2);

    logic          line_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            line_q <= bus_in;
            if (bus_in)
                low_cnt <= '0;
            else if (tick_en && !own_pull && (low_cnt <= CW'(T_RST)))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // A falling edge caused by our own pull-down is not a master slot.
    assign fell    = line_q & ~bus_in & ~own_pull;
    assign rst_req = ~bus_in & tick_en & ~own_pull & (low_cnt == CW'(T_RST));

endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import onewire_id_pkg::*;
#(
    parameter int T_PWAIT  = 30,
    parameter int T_PLEN   = 120,
    parameter int T_SAMPLE = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               bus_in,
    input  logic               fell,
    input  logic               rst_req,
    input  logic [ID_BITS-1:0] id_word,
    output logic               pull,
    output logic               selected,
    output logic               in_presence
);

    localparam int TMAX0 = (T_PLEN > T_PWAIT) ? T_PLEN : T_PWAIT;
    localparam int TMAX  = (TMAX0 > T_SAMPLE) ? TMAX0 : T_SAMPLE;
    localparam int TW    = $clog2(TMAX + 1);

    eng_state_t     st, st_n;
    logic [TW-1:0]  tcnt, tcnt_n;
    logic           id_bit;
    logic           slot_read;
    logic           tx_bit;
    logic           last_bit;
    logic [7:0]     cmd_next;

    assign id_bit    = id_word[st.idx];
    assign last_bit  = (st.idx == IDX_W'(ID_BITS - 1));
    assign slot_read = (st.phase == PH_READ) ||
                       ((st.phase == PH_SEARCH) && (st.sub != SR_DIR));
    assign tx_bit    = ((st.phase == PH_SEARCH) && (st.sub == SR_CMPL)) ? ~id_bit : id_bit;
    assign cmd_next  = {bus_in, st.cmd[7:1]};

    always_comb begin
        st_n   = st;
        tcnt_n = tcnt;
        if (rst_req) begin
            st_n.phase   = PH_RST_LOW;
            st_n.in_slot = 1'b0;
            st_n.pull    = 1'b0;
            st_n.sel     = 1'b0;
            tcnt_n       = '0;
        end else begin
            case (st.phase)
                PH_RST_LOW: begin
                    if (bus_in) begin
                        st_n.phase = PH_PRES_WAIT;
                        tcnt_n     = '0;
                    end
                end
                PH_PRES_WAIT: begin
                    if (tick_en) begin
                        if (tcnt == TW'(T_PWAIT - 1)) begin
                            st_n.phase = PH_PRES_DRV;
                            st_n.pull  = 1'b1;
                            tcnt_n     = '0;
                        end else begin
                            tcnt_n = tcnt + 1'b1;
                        end
                    end
                end
                PH_PRES_DRV: begin
                    if (tick_en) begin
                        if (tcnt == TW'(T_PLEN - 1)) begin
                            st_n.phase   = PH_CMD;
                            st_n.pull    = 1'b0;
                            st_n.bcnt    = '0;
                            st_n.cmd     = '0;
                            st_n.in_slot = 1'b0;
                            tcnt_n       = '0;
                        end else begin
                            tcnt_n = tcnt + 1'b1;
                        end
                    end
                end
                PH_CMD, PH_READ, PH_MATCH, PH_SEARCH: begin
                    if (fell) begin
                        st_n.in_slot = 1'b1;
                        st_n.pull    = slot_read && !tx_bit;
                        tcnt_n       = '0;
                    end else if (st.in_slot && tick_en) begin
                        if (tcnt == TW'(T_SAMPLE - 1)) begin
                            st_n.in_slot = 1'b0;
                            st_n.pull    = 1'b0;
                            case (st.phase)
                                PH_CMD: begin
                                    st_n.cmd = cmd_next;
                                    if (st.bcnt == 3'd7) begin
                                        st_n.phase = decode_cmd(cmd_next);
                                        st_n.idx   = '0;
                                        st_n.sub   = SR_TRUE;
                                    end else begin
                                        st_n.bcnt = st.bcnt + 3'd1;
                                    end
                                end
                                PH_READ: begin
                                    if (last_bit) begin
                                        st_n.phase = PH_QUIET;
                                        st_n.sel   = 1'b1;
                                    end else begin
                                        st_n.idx = st.idx + 1'b1;
                                    end
                                end
                                PH_MATCH: begin
                                    if (bus_in != id_bit) begin
                                        st_n.phase = PH_QUIET;
                                    end else if (last_bit) begin
                                        st_n.phase = PH_QUIET;
                                        st_n.sel   = 1'b1;
                                    end else begin
                                        st_n.idx = st.idx + 1'b1;
                                    end
                                end
                                default: begin
                                    case (st.sub)
                                        SR_TRUE: st_n.sub = SR_CMPL;
                                        SR_CMPL: st_n.sub = SR_DIR;
                                        default: begin
                                            if (bus_in != id_bit) begin
                                                st_n.phase = PH_QUIET;
                                            end else if (last_bit) begin
                                                st_n.phase = PH_QUIET;
                                                st_n.sel   = 1'b1;
                                            end else begin
                                                st_n.idx = st.idx + 1'b1;
                                                st_n.sub = SR_TRUE;
                                            end
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            tcnt_n = tcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase   <= PH_QUIET;
            st.sub     <= SR_TRUE;
            st.idx     <= '0;
            st.bcnt    <= '0;
            st.cmd     <= '0;
            st.in_slot <= 1'b0;
            st.pull    <= 1'b0;
            st.sel     <= 1'b0;
            tcnt       <= '0;
        end else begin
            st   <= st_n;
            tcnt <= tcnt_n;
        end
    end

    assign pull        = st.pull;
    assign selected    = st.sel;
    assign in_presence = (st.phase == PH_PRES_DRV);

endmodule

// File: rtl/onewire_id_responder.sv
module onewire_id_responder
    import onewire_id_pkg::*;
#(
    parameter logic [SER_BITS-1:0] SERIAL_NUM = 48'h0000_0000_0001,
    parameter int                  T_RST      = 120,
    parameter int                  T_PWAIT    = 30,
    parameter int                  T_PLEN     = 120,
    parameter int                  T_SAMPLE   = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic bus_in,
    output logic bus_pull,
    output logic selected
);

    logic [ID_BITS-1:0] id_word;
    logic               fell;
    logic               rst_req;
    logic               pull_int;
    logic               in_presence;

    ow_id_rom #(
        .SERIAL_NUM(SERIAL_NUM)
    ) u_rom (
        .id_word(id_word)
    );

    ow_line_monitor #(
        .T_RST(T_RST)
    ) u_mon (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .bus_in  (bus_in),
        .own_pull(pull_int),
        .fell    (fell),
        .rst_req (rst_req)
    );

    ow_slot_engine #(
        .T_PWAIT (T_PWAIT),
        .T_PLEN  (T_PLEN),
        .T_SAMPLE(T_SAMPLE)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .bus_in     (bus_in),
        .fell       (fell),
        .rst_req    (rst_req),
        .id_word    (id_word),
        .pull       (pull_int),
        .selected   (selected),
        .in_presence(in_presence)
    );

    assign bus_pull = pull_int;

endmodule

// File: rtl/ow_id_checker.sv
module ow_id_checker #(
    parameter int T_RST    = 120,
    parameter int T_PLEN   = 120,
    parameter int T_SAMPLE = 30
) (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic bus_in,
    input logic bus_pull,
    input logic selected,
    input logic in_presence
);

    logic [15:0] pull_ticks;
    logic [15:0] low_ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_ticks <= '0;
            low_ticks  <= '0;
        end else begin
            if (!bus_pull)
                pull_ticks <= '0;
            else if (tick_en)
                pull_ticks <= pull_ticks + 16'd1;
            if (bus_in)
                low_ticks <= '0;
            else if (tick_en && !bus_pull && (low_ticks <= 16'(T_RST)))
                low_ticks <= low_ticks + 16'd1;
        end
    end

    p_pull_origin_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_pull) |-> (in_presence || !$past(bus_in)));

    p_slot_pull_len_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_pull) && !$past(in_presence)) |-> (pull_ticks == 16'(T_SAMPLE)));

    p_presence_len_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_pull) && $past(in_presence)) |-> (pull_ticks == 16'(T_PLEN)));

    p_reset_clears_sel_r4: assert property (@(posedge clk) disable iff (rst)
        (low_ticks > 16'(T_RST)) |-> !selected);

    p_reset_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (low_ticks > 16'(T_RST)) |-> !bus_pull);

    p_sel_after_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> !bus_pull);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_idle_in_reset_r3: assert (!bus_pull);
        end
    end

endmodule

bind onewire_id_responder ow_id_checker #(
    .T_RST   (T_RST),
    .T_PLEN  (T_PLEN),
    .T_SAMPLE(T_SAMPLE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .bus_in     (bus_in),
    .bus_pull   (bus_pull),
    .selected   (selected),
    .in_presence(in_presence)
);

// File: tb/onewire_id_responder_test.sv
module onewire_id_responder_test;

    localparam logic [47:0] SER = 48'h5A3C_9E01_77B2;

    logic clk;
    logic rst;
    logic tick_en;
    logic m_low;
    logic bus_in;
    logic bus_pull;
    logic selected;
    int   n_chk;
    int   n_fail;

    assign bus_in = ~(m_low | bus_pull);

    onewire_id_responder #(.SERIAL_NUM(SER)) uut (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .bus_in  (bus_in),
        .bus_pull(bus_pull),
        .selected(selected)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    initial begin
        tick_en = 1'b0;
        forever begin
            @(negedge clk);
            tick_en = ~tick_en;
        end
    end

    function automatic logic [63:0] ref_id(input logic [47:0] s);
        logic [55:0] body;
        logic [7:0]  c;
        body = {s, 8'h01};
        c    = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb;
            fb = c[0] ^ body[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return {c, body};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wait_t(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic reset_pres(output logic ok);
        logic s1, s2, s3;
        m_low = 1'b1;
        wait_t(200);
        m_low = 1'b0;
        wait_t(10);
        s1 = bus_in;
        wait_t(70);
        s2 = bus_in;
        wait_t(100);
        s3 = bus_in;
        wait_t(20);
        ok = s1 && !s2 && s3;
    endtask

    task automatic write_bit(input logic b);
        m_low = 1'b1;
        wait_t(2);
        if (b) m_low = 1'b0;
        wait_t(58);
        m_low = 1'b0;
        wait_t(7);
    endtask

    task automatic read_bit(output logic early, output logic late);
        m_low = 1'b1;
        wait_t(2);
        m_low = 1'b0;
        wait_t(13);
        early = bus_in;
        wait_t(25);
        late = bus_in;
        wait_t(27);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) write_bit(b[i]);
    endtask

    task automatic read_n(input int n, output logic [63:0] w);
        logic e, l;
        w = '0;
        for (int i = 0; i < n; i++) begin
            read_bit(e, l);
            w[i] = e;
        end
    endtask

    initial begin
        n_chk  = 0;
        n_fail = 0;
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [63:0] exp_id;
        logic [63:0] w;
        logic        e, l, ok, t, c;
        int          k, errs;
        logic [7:0]  op;

        void'($urandom(32'd4711));
        exp_id = ref_id(SER);
        m_low  = 1'b0;
        rst    = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 reset state pull/selected", {62'b0, bus_pull, selected}, 64'd0);
        rst = 1'b0;
        wait_t(5);

        // R5 presence pulse timing
        reset_pres(ok);
        chk("R5 presence window", {63'b0, ok}, 64'd1);

        // R7 partial read, then R4 reset override mid-transaction
        send_byte(8'h33);
        read_bit(e, l);
        chk("R7 read bit0", {63'b0, e}, {63'b0, exp_id[0]});
        read_bit(e, l);
        chk("R7 read bit1 pulled", {63'b0, e}, {63'b0, exp_id[1]});
        chk("R3 pull released after slot window", {63'b0, l}, 64'd1);
        read_n(3, w);
        chk("R7 read bits 2..4", {61'b0, w[2:0]}, {61'b0, exp_id[4:2]});
        reset_pres(ok);
        chk("R4 presence after mid-read reset", {63'b0, ok}, 64'd1);
        chk("R4 selected low after reset", {63'b0, selected}, 64'd0);

        // R7 full read with second opcode, R1/R2 layout
        send_byte(8'h0F);
        read_n(64, w);
        chk("R7 full identity", w, exp_id);
        chk("R1 family byte", {56'b0, w[7:0]}, 64'h01);
        chk("R1 serial field", {16'b0, w[55:8]}, {16'b0, SER});
        chk("R2 checksum byte", {56'b0, w[63:56]}, {56'b0, exp_id[63:56]});
        chk("R7 selected after read", {63'b0, selected}, 64'd1);
        read_n(4, w);
        chk("R11 silent after read", {60'b0, w[3:0]}, 64'hF);

        // R8 match with own identity
        reset_pres(ok);
        chk("R4 selected cleared by reset", {63'b0, selected}, 64'd0);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) write_bit(exp_id[i]);
        chk("R8 match selects", {63'b0, selected}, 64'd1);
        read_n(2, w);
        chk("R11 silent after match", {62'b0, w[1:0]}, 64'h3);

        // R8 match with one bit flipped
        k = int'($urandom % 64);
        reset_pres(ok);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) write_bit(exp_id[i] ^ (i == k));
        chk("R8 mismatch leaves unselected", {63'b0, selected}, 64'd0);
        read_n(8, w);
        chk("R8 silent after mismatch", {56'b0, w[7:0]}, 64'hFF);

        // R9 full search
        reset_pres(ok);
        send_byte(8'hF0);
        errs = 0;
        for (int i = 0; i < 64; i++) begin
            read_bit(t, l);
            read_bit(c, l);
            if (t !== exp_id[i] || c !== ~exp_id[i]) errs++;
            write_bit(exp_id[i]);
        end
        chk("R9 bit/complement pairs", 64'(errs), 64'd0);
        chk("R9 search selects", {63'b0, selected}, 64'd1);

        // R9 search dropped at a random round
        k = int'($urandom % 24);
        reset_pres(ok);
        send_byte(8'hF0);
        for (int i = 0; i < k; i++) begin
            read_bit(t, l);
            read_bit(c, l);
            write_bit(exp_id[i]);
        end
        read_bit(t, l);
        read_bit(c, l);
        chk("R9 pair at drop round", {62'b0, t, c}, {62'b0, exp_id[k], ~exp_id[k]});
        write_bit(~exp_id[k]);
        read_n(2, w);
        chk("R9 silent after losing round", {62'b0, w[1:0]}, 64'h3);
        chk("R9 unselected after drop", {63'b0, selected}, 64'd0);

        // R6 bit order: reversed 33h must not be read as Read ROM
        reset_pres(ok);
        send_byte(8'hCC);
        read_n(8, w);
        chk("R6 reversed opcode ignored", {56'b0, w[7:0]}, 64'hFF);
        chk("R6 no selection", {63'b0, selected}, 64'd0);

        // R10 random unknown opcodes
        for (int r = 0; r < 2; r++) begin
            do op = 8'($urandom);
            while (op == 8'h33 || op == 8'h0F || op == 8'h55 || op == 8'hF0);
            reset_pres(ok);
            send_byte(op);
            read_n(8, w);
            chk("R10 unknown opcode silent", {56'b0, w[7:0]}, 64'hFF);
            chk("R10 unknown opcode unselected", {63'b0, selected}, 64'd0);
        end

        report();
        $finish;
    end

endmodule